// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter that must be serviced on time, and only at the right time. After each restart the counter runs upward from zero toward a configured overflow count. Software services it by writing a fixed key byte through a one-cycle write strobe. A key write is accepted only in the open part of the count period. The open part is the final fraction of the period, and the closed part comes first.

The block raises a one-cycle internal reset request in three cases: the count reaches overflow without a service, the key arrives while the window is closed, or any other byte is written. The first write after a reset is exempt from the window check. This lets start-up code service the timer without knowing where the count stands. A standby-enable option bit set to 0 forces the whole period open. The window code, standby bit and overflow count are static configuration and may change only while reset is held.

Top module: `wdt_window`

## Requirements
- R1: While and directly after the asynchronous reset, `rst_req` is 0, the count is 0 and the first-write exemption is armed.
- R2: The count rises by one every clock from 0. If a clock edge finds the count equal to `cfg_ovf` and no accepted service in that cycle, `rst_req` is 1 for the following cycle. An unserviced period therefore lasts `cfg_ovf`+1 cycles.
- R3: `rst_req` is high for a single cycle per abnormality. With that pulse the count restarts at 0 and the first-write exemption is armed again, exactly as after R1.
- R4: A write of 0xAC while the window is open clears the count to 0 and raises no request. This includes a write at count equal to `cfg_ovf`.
- R5: A write of 0xAC while the window is closed, once the first write has been used, raises `rst_req` on the next cycle.
- R6: A write of any byte other than 0xAC raises `rst_req` on the next cycle. This holds whether the window is open or closed, and holds for the first write too.
- R7: The first 0xAC write after a reset or a request is accepted at any count, with no window check.
- R8: With `cfg_stby_en`=1, the window is closed while the count is below a limit and open from the limit on. The limit is `cfg_ovf`>>1 for `cfg_win`=01 (50% open), `cfg_ovf`>>2 for 10 (75% open) and 0 for 11 (always open). A write exactly at the limit is accepted.
- R9: The reserved code `cfg_win`=00 behaves as code 11.
- R10: With `cfg_stby_en`=0, the window is always open whatever `cfg_win` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_win | input | 2 | Window size code (01 50%, 10 75%, 11 100%, 00 reserved) |
| cfg_stby_en | input | 1 | Standby-enable option bit; 0 forces a fully open window |
| cfg_ovf | input | CNT_W | Overflow count |
| wr_en | input | 1 | Service register write strobe |
| wr_data | input | 8 | Byte written to the service register |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The count and the first-write flag are hidden, so errors in them appear only at `rst_req`. A count that drifts or misses its restart moves the overflow pulse by whole cycles, or turns a boundary write into a false request one cycle after the write. A flag that is lost or stuck shows on the first key write after a reset or request: the write either gets a pulse it should not get or escapes one it should. Each error therefore becomes visible within one overflow period, and directed writes at the window limit and one cycle before it expose an off-by-one in the limit.

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int unsigned CNT_W = 16,
  parameter logic [7:0]  KEY   = 8'hAC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_win,
  input  logic             cfg_stby_en,
  input  logic [CNT_W-1:0] cfg_ovf,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic             rst_req
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] close_lim;
  logic             first;

  always_comb begin
    close_lim = '0;
    if (cfg_stby_en) begin
      case (cfg_win)
        2'b01:   close_lim = cfg_ovf >> 1;
        2'b10:   close_lim = cfg_ovf >> 2;
        default: close_lim = '0;
      endcase
    end
  end

  wire win_open = (cnt >= close_lim);
  wire key_ok   = (wr_data == KEY);
  wire svc      = wr_en && key_ok && (first || win_open);
  wire abn      = wr_en && !svc;
  wire ovf_hit  = (cnt >= cfg_ovf) && !svc;
  wire fault    = abn || ovf_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      first   <= 1'b1;
      rst_req <= 1'b0;
    end else if (fault) begin
      cnt     <= '0;
      first   <= 1'b1;
      rst_req <= 1'b1;
    end else if (svc) begin
      cnt     <= '0;
      first   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      cnt     <= cnt + 1'b1;
      rst_req <= 1'b0;
    end
  end

endmodule

module wdt_window_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_stby_en,
  input logic [CNT_W-1:0] cfg_ovf,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             rst_req,
  input logic [CNT_W-1:0] cnt,
  input logic             first
);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cfg_ovf);

  a_r2_overflow_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == cfg_ovf && !wr_en) |=> rst_req);

  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt == '0 && first));

  a_r6_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data != 8'hAC) |=> rst_req);

  a_r7_first_exempt: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 8'hAC && first) |=> (!rst_req && cnt == '0 && !first));

  a_r10_open_always: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_stby_en && wr_en && wr_data == 8'hAC) |=> !rst_req);

endmodule

bind wdt_window wdt_window_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_stby_en(cfg_stby_en), .cfg_ovf(cfg_ovf),
  .wr_en(wr_en), .wr_data(wr_data), .rst_req(rst_req), .cnt(cnt), .first(first)
);

// File: tb/wdt_window_tb.sv
module wdt_window_tb;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    win = 2'b01;
  logic          stby = 1'b1;
  logic [CW-1:0] ovf = 16'd40;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = 8'h00;
  wire           rst_req;

  always #10 clk = ~clk;

  wdt_window #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_win(win), .cfg_stby_en(stby), .cfg_ovf(ovf),
    .wr_en(wr_en), .wr_data(wr_data), .rst_req(rst_req)
  );

  int    checks = 0;
  int    errors = 0;
  int    m_cnt;
  bit    m_first;
  bit    m_req;
  string m_tag = "R1";
  string scen = "R1";
  bit    done = 1'b0;

  function automatic int lim_of(logic [1:0] w, logic s, int o);
    if (!s) return 0;
    case (w)
      2'b01:   return o >> 1;
      2'b10:   return o >> 2;
      default: return 0;
    endcase
  endfunction

  task automatic check_out();
    checks++;
    if (rst_req !== m_req) begin
      errors++;
      $display("FAIL %s (%s): rst_req=%b expected %b", scen, m_tag, rst_req, m_req);
    end
  endtask

  task automatic step(bit we, logic [7:0] d);
    bit key, open, svc, ovh;
    wr_en = we;
    wr_data = d;
    key  = (d == 8'hAC);
    open = (m_cnt >= lim_of(win, stby, int'(ovf)));
    svc  = we && key && (m_first || open);
    ovh  = (m_cnt >= int'(ovf)) && !svc;
    if (we && !key)           m_tag = "R6";
    else if (svc && m_first)  m_tag = "R7";
    else if (svc)             m_tag = "R4";
    else if (we)              m_tag = "R5";
    else                      m_tag = "R2";
    if ((we && !svc) || ovh) begin
      m_cnt = 0; m_first = 1'b1; m_req = 1'b1;
    end else if (svc) begin
      m_cnt = 0; m_first = 1'b0; m_req = 1'b0;
    end else begin
      m_cnt++; m_req = 1'b0;
    end
    @(negedge clk);
    check_out();
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00);
  endtask

  task automatic wait_cnt(int n);
    while (m_cnt != n) step(1'b0, 8'h00);
  endtask

  task automatic do_reset(logic [1:0] w, logic s, int o);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    win = w; stby = s; ovf = CW'(o);
    m_cnt = 0; m_first = 1'b1; m_req = 1'b0; m_tag = "R1";
    @(negedge clk);
    scen = "R1 reset";
    check_out();
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R1 + R2: overflow with no service
    do_reset(2'b01, 1'b1, 40);
    scen = "R2 overflow"; idle(45);
    // R7, R5, R3
    do_reset(2'b01, 1'b1, 40);
    scen = "R7 first write in closed window"; idle(3); step(1'b1, 8'hAC);
    scen = "R5 key in closed window"; idle(5); step(1'b1, 8'hAC);
    scen = "R3 single pulse then rearmed"; idle(2); step(1'b1, 8'hAC);
    // R8 50% boundary, ovf 40 -> limit 20
    scen = "R8 50% at limit"; wait_cnt(20); step(1'b1, 8'hAC);
    scen = "R8 50% one before limit"; wait_cnt(19); step(1'b1, 8'hAC);
    // R8 75%, limit 10
    do_reset(2'b10, 1'b1, 40);
    scen = "R8 75% exempt"; step(1'b1, 8'hAC);
    scen = "R8 75% at limit"; wait_cnt(10); step(1'b1, 8'hAC);
    scen = "R8 75% one before limit"; wait_cnt(9); step(1'b1, 8'hAC);
    // R8 100%
    do_reset(2'b11, 1'b1, 40);
    step(1'b1, 8'hAC);
    scen = "R8 100% early key"; wait_cnt(1); step(1'b1, 8'hAC);
    // R9 reserved code
    do_reset(2'b00, 1'b1, 40);
    step(1'b1, 8'hAC);
    scen = "R9 code 00 open"; wait_cnt(1); step(1'b1, 8'hAC);
    // R10 standby bit clear
    do_reset(2'b01, 1'b0, 40);
    step(1'b1, 8'hAC);
    scen = "R10 standby off open"; wait_cnt(2); step(1'b1, 8'hAC);
    // R6 bad key
    do_reset(2'b01, 1'b1, 40);
    scen = "R6 bad key first write"; idle(2); step(1'b1, 8'h55);
    step(1'b1, 8'hAC);
    scen = "R6 bad key open window"; wait_cnt(30); step(1'b1, 8'hAB);
    // R4 service at last count
    do_reset(2'b01, 1'b1, 40);
    step(1'b1, 8'hAC);
    scen = "R4 service at overflow count"; wait_cnt(40); step(1'b1, 8'hAC); idle(3);
    // random rounds
    for (int r = 0; r < 8; r++) begin
      do_reset(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom_range(6, 60));
      scen = "R2 random";
      for (int i = 0; i < 500; i++) begin
        if ($urandom_range(0, 11) == 0)
          step(1'b1, ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'hAC);
        else
          step(1'b0, 8'h00);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule